// File: doc/BRIEF.md
# SPI Slave with Select-Release Detect

This block is the target side of a four-wire serial link. The serial clock, the data-in line and the active-low select arrive from an external master. The block brings all three into the system clock domain through two-flop synchronizers and detects their edges there. Bytes are exchanged MSB first, 8 bits at a time. Each byte sent out of the data-out line comes from a single transmit holding register. Each byte received lands in a single receive register.

Software configures clock polarity and phase, loads the next outgoing byte and collects incoming ones over a small register bus. Read data on this bus is combinational. A read takes effect at the clock edge where `reg_rd_i` is high. When the select line is released, a sticky flag marks the end of the transaction, and this flag can drive the interrupt line. If the master keeps clocking and software has not supplied a new byte, the previous byte is sent again and an underrun is flagged.

The serial clock must run at no more than one quarter of the system clock.

Top module: `spi_sel_slave`

Register map (3-bit address): 0 = configuration (bit 1 clock polarity, bit 0 clock phase; reset 0). 1 = status, read clears bits 2 to 4 (bit 0 receive full, bit 1 transmit empty, bit 2 overrun, bit 3 underrun, bit 4 select released; reset value 0x02). 2 = receive data, read clears receive full. 3 = transmit data, write only. 4 = interrupt enable, write 1 to set. 5 = interrupt disable, write 1 to clear. 6 = interrupt mask, read only, with the same bit positions as status (reset 0).

## Requirements
- R1: Configuration bit 1 selects the idle clock level and bit 0 selects the phase. Phase 0 samples on the leading edge and phase 1 samples on the trailing edge. In all four modes, bytes move MSB first in both directions.
- R2: The output enable is high only while select is low. In phase 0, the first data-out bit is present after select falls and before the first clock edge.
- R3: The byte last written to transmit data before select falls is the first byte sent. A second write replaces the first, and writing clears transmit empty.
- R4: When the master clocks a byte for which no new transmit byte was written, the last fully sent byte is sent again and status bit 3 (underrun) is set.
- R5: A completed received byte sets status bit 0. A read of receive data returns that byte and clears status bit 0.
- R6: A byte that completes while status bit 0 is still set sets status bit 2 (overrun), and receive data then holds the newest byte.
- R7: A rising edge of select sets status bit 4. The bit stays set until status is read, and the read clears it.
- R8: Writing 1s to address 4 sets mask bits, and writing 1s to address 5 clears them. Address 6 reads the mask. `irq_o` is high exactly when a status bit and its mask bit are both 1.
- R9: Select rising in the middle of a byte discards the partial byte: no receive event occurs, and the next transaction starts at its first bit.
- R10: A status read clears the overrun, underrun and select-released bits. The reset status value is 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| csn_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A bit counter that is out of step, for example one not cleared after an aborted byte, shows on the next transaction. Received data arrives rotated and outgoing bytes are shifted, so it is caught within 8 serial clocks. A wrong fresh/stale decision for the holding register shows as a wrong byte on data-out, or as a wrong underrun bit, at the first status read after the transaction. Flag set/clear priority errors show in status or on `irq_o` within a few system cycles of select rising.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int STAT_W = 5;

  localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RXD   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TXD   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IDIS  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_IMASK = 3'd6;

  // status bit positions
  localparam int ST_RXF  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_URUN = 3;
  localparam int ST_SELR = 4;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          mosi_s_i,
  input  logic          csn_s_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_wdata_i,
  output logic          tx_empty_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          urun_o,
  output logic          sel_rise_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic [DW-1:0]    hold_q, tx_sr_q, cur_q, last_q, rx_sr_q, rx_data_q;
  logic             hold_full_q, fresh_q, csn_q, sck_q, rx_valid_q, urun_q;
  logic [CNT_W-1:0] bcnt_q;

  logic sck_edge, lead, trail, active, samp, drv, sel_fall, first_samp, consume;
  logic [DW-1:0] next_byte, start_byte;

  assign sck_edge   = sck_s_i ^ sck_q;
  assign lead       = sck_edge & (sck_s_i != cpol_i);
  assign trail      = sck_edge & (sck_s_i == cpol_i);
  assign active     = ~csn_s_i & ~csn_q;
  assign samp       = active & (cpha_i ? trail : lead);
  assign drv        = active & (cpha_i ? lead : trail);
  assign sel_fall   = csn_q & ~csn_s_i;
  assign sel_rise_o = ~csn_q & csn_s_i;
  assign first_samp = samp & (bcnt_q == '0);
  // a byte loaded from the holding register is only claimed once the master clocks it
  assign consume    = first_samp & fresh_q;
  assign next_byte  = hold_full_q ? hold_q : cur_q;
  assign start_byte = hold_full_q ? hold_q : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (tx_wr_i) begin
      hold_q      <= tx_wdata_i;
      hold_full_q <= 1'b1;
    end else if (consume) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q      <= 1'b1;
      sck_q      <= 1'b0;
      bcnt_q     <= '0;
      tx_sr_q    <= '0;
      cur_q      <= '0;
      last_q     <= '0;
      rx_sr_q    <= '0;
      rx_data_q  <= '0;
      fresh_q    <= 1'b0;
      rx_valid_q <= 1'b0;
      urun_q     <= 1'b0;
    end else begin
      csn_q      <= csn_s_i;
      sck_q      <= sck_s_i;
      rx_valid_q <= 1'b0;
      urun_q     <= 1'b0;
      if (csn_s_i) begin
        bcnt_q <= '0;
      end else if (sel_fall) begin
        tx_sr_q <= start_byte;
        cur_q   <= start_byte;
        fresh_q <= hold_full_q;
        bcnt_q  <= '0;
      end else if (samp) begin
        rx_sr_q <= {rx_sr_q[DW-2:0], mosi_s_i};
        if (first_samp && !fresh_q) urun_q <= 1'b1;
        if (bcnt_q == LAST_BIT) begin
          bcnt_q     <= '0;
          rx_valid_q <= 1'b1;
          rx_data_q  <= {rx_sr_q[DW-2:0], mosi_s_i};
          last_q     <= cur_q;
          tx_sr_q    <= next_byte;
          cur_q      <= next_byte;
          fresh_q    <= hold_full_q;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end else if (drv && bcnt_q != '0) begin
        tx_sr_q <= {tx_sr_q[DW-2:0], 1'b0};
      end
    end
  end

  assign miso_o     = tx_sr_q[DW-1];
  assign miso_oe_o  = ~csn_q;
  assign tx_empty_o = ~hold_full_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign urun_o     = urun_q;

  AST_IDLE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> (bcnt_q == '0)); // R9
  AST_HOLD_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && !tx_wr_i) |=> tx_empty_o); // R3
  AST_OE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fall |=> miso_oe_o); // R2
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic              tx_wr_o,
  output logic [DATA_W-1:0] tx_wdata_o,
  input  logic              tx_empty_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              urun_i,
  input  logic              sel_rise_i
);
  logic [1:0]        cfg_q;
  logic [STAT_W-1:0] mask_q, stat;
  logic [DATA_W-1:0] rx_hold_q;
  logic              rx_full_q, ovr_q, urun_q, selr_q;
  logic              rd_stat, rd_rx;

  assign rd_stat = reg_rd_i & (reg_addr_i == ADR_STAT);
  assign rd_rx   = reg_rd_i & (reg_addr_i == ADR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        ADR_CFG:  cfg_q  <= reg_wdata_i[1:0];
        ADR_IEN:  mask_q <= mask_q | reg_wdata_i[STAT_W-1:0];
        ADR_IDIS: mask_q <= mask_q & ~reg_wdata_i[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  // set wins over read-clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_hold_q <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      urun_q    <= 1'b0;
      selr_q    <= 1'b0;
    end else begin
      if (rx_valid_i)      rx_hold_q <= rx_data_i;
      if (rx_valid_i)      rx_full_q <= 1'b1;
      else if (rd_rx)      rx_full_q <= 1'b0;
      if (rx_valid_i && rx_full_q && !rd_rx) ovr_q <= 1'b1;
      else if (rd_stat)    ovr_q <= 1'b0;
      if (urun_i)          urun_q <= 1'b1;
      else if (rd_stat)    urun_q <= 1'b0;
      if (sel_rise_i)      selr_q <= 1'b1;
      else if (rd_stat)    selr_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_RXF]  = rx_full_q;
    stat[ST_TXE]  = tx_empty_i;
    stat[ST_OVR]  = ovr_q;
    stat[ST_URUN] = urun_q;
    stat[ST_SELR] = selr_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_CFG:   reg_rdata_o[1:0]        = cfg_q;
      ADR_STAT:  reg_rdata_o[STAT_W-1:0] = stat;
      ADR_RXD:   reg_rdata_o             = rx_hold_q;
      ADR_IMASK: reg_rdata_o[STAT_W-1:0] = mask_q;
      default: ;
    endcase
  end

  assign irq_o      = |(stat & mask_q);
  assign cpol_o     = cfg_q[1];
  assign cpha_o     = cfg_q[0];
  assign tx_wr_o    = reg_wr_i & (reg_addr_i == ADR_TXD);
  assign tx_wdata_o = reg_wdata_i;

  AST_SELR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rise_i |=> selr_q); // R7
  AST_SELR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selr_q && !rd_stat) |=> selr_q); // R7
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full_q && !rd_rx) |=> ovr_q); // R6
  AST_RXF_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(rx_valid_i)); // R5
  AST_URUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_i |=> urun_q); // R4
  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R8
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [2:0]        pins_s;
  logic              cpol, cpha, tx_wr, tx_empty, rx_valid, urun, sel_rise;
  logic [DATA_W-1:0] tx_wdata, rx_data;

  // order: {select, data-in, clock}; select idles high
  spi_in_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, mosi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_shift_engine #(.DW(DATA_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s[0]),
    .mosi_s_i  (pins_s[1]),
    .csn_s_i   (pins_s[2]),
    .cpol_i    (cpol),
    .cpha_i    (cpha),
    .tx_wr_i   (tx_wr),
    .tx_wdata_i(tx_wdata),
    .tx_empty_o(tx_empty),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o),
    .rx_valid_o(rx_valid),
    .rx_data_o (rx_data),
    .urun_o    (urun),
    .sel_rise_o(sel_rise)
  );

  spi_reg_bank u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .cpol_o     (cpol),
    .cpha_o     (cpha),
    .tx_wr_o    (tx_wr),
    .tx_wdata_o (tx_wdata),
    .tx_empty_i (tx_empty),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .urun_i     (urun),
    .sel_rise_i (sel_rise)
  );
endmodule

// File: tb/spi_sel_slave_test.sv
module spi_sel_slave_test;
  localparam int HALF = 8;

  logic       clk = 0, rst_n = 0;
  logic       sck_b = 0, mosi_b = 0, csn_b = 1;
  logic       miso_o, miso_oe_o, irq_o;
  logic [2:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic       cpol_b = 0, cpha_b = 0;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  spi_sel_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck_b), .mosi_i(mosi_b), .csn_i(csn_b),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #5 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_mode(input logic [1:0] m);
    reg_wr(3'd0, {6'b0, m});
    cpol_b = m[1]; cpha_b = m[0];
    sck_b = m[1];
    wait_clk(4);
  endtask

  // clocks nbits of mo, MSB first
  task automatic spi_bits(input logic [7:0] mo, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha_b) begin
        mosi_b = mo[i];
        wait_clk(HALF); sck_b = ~cpol_b;
        wait_clk(HALF); sck_b = cpol_b;
      end else begin
        sck_b = ~cpol_b; mosi_b = mo[i];
        wait_clk(HALF); sck_b = cpol_b;
        wait_clk(HALF);
      end
    end
  endtask

  // driver: queue the byte expected on data-out, then clock it
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_miso);
    exp_q.push_back(exp_miso);
    spi_bits(mo, 8);
  endtask

  task automatic sel_low();  csn_b = 0; wait_clk(HALF); endtask
  task automatic sel_high(); wait_clk(HALF); csn_b = 1; wait_clk(6); endtask

  // monitor: samples data-out on master sample edges, compares whole bytes
  logic       prev_sck = 0;
  int         mbits = 0;
  logic [7:0] mbyte = 0;
  always @(sck_b or csn_b) begin
    if (csn_b) mbits = 0;
    else if (sck_b !== prev_sck) begin
      if (cpha_b ? (sck_b == cpol_b) : (sck_b != cpol_b)) begin
        mbyte = {mbyte[6:0], miso_o};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (exp_q.size() == 0) chk("R1 unexpected byte", mbyte, 8'hxx);
          else chk("R1 data-out byte", mbyte, exp_q.pop_front());
        end
      end
    end
    prev_sck = sck_b;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    // reset state
    rd_chk("R10 reset status", 3'd1, 8'h02);
    rd_chk("R8 reset mask", 3'd6, 8'h00);
    rd_chk("R1 reset cfg", 3'd0, 8'h00);
    chk("R2 oe idle", {7'b0, miso_oe_o}, 8'h00);
    chk("R8 irq idle", {7'b0, irq_o}, 8'h00);

    // mode 0, replaced holding byte
    set_mode(2'd0);
    reg_wr(3'd3, 8'h11);
    reg_wr(3'd3, 8'hA5);
    rd_chk("R3 tx not empty", 3'd1, 8'h00);
    csn_b = 0;
    wait_clk(5);
    chk("R2 oe on select", {7'b0, miso_oe_o}, 8'h01);
    chk("R2 first bit before clock", {7'b0, miso_o}, 8'h01);
    wait_clk(HALF - 5);
    xfer(8'h3C, 8'hA5);
    sel_high();
    chk("R2 oe off after release", {7'b0, miso_oe_o}, 8'h00);
    rd_chk("R7 status after release", 3'd1, 8'h13);
    rd_chk("R7 select flag cleared", 3'd1, 8'h03);
    rd_chk("R5 rx data", 3'd2, 8'h3C);
    rd_chk("R5 rx full cleared", 3'd1, 8'h02);

    // other modes: fresh byte then repeat with underrun, overrun
    begin
      logic [7:0] tv [3] = '{8'hC3, 8'h81, 8'h6E};
      logic [7:0] m1 [3] = '{8'h5A, 8'h0F, 8'h12};
      logic [7:0] m2 [3] = '{8'h96, 8'hF0, 8'h34};
      for (int k = 0; k < 3; k++) begin
        set_mode(2'(k + 1));
        rd_chk("R1 cfg readback", 3'd0, 8'(k + 1));
        reg_wr(3'd3, tv[k]);
        sel_low();
        xfer(m1[k], tv[k]);
        xfer(m2[k], tv[k]);   // R4 repeated byte
        sel_high();
        rd_chk("R4 R6 status underrun overrun", 3'd1, 8'h1F);
        rd_chk("R6 newest rx byte", 3'd2, m2[k]);
        rd_chk("R10 flags cleared by read", 3'd1, 8'h02);
      end
    end

    // partial byte discarded
    set_mode(2'd0);
    reg_wr(3'd3, 8'h00);
    sel_low();
    spi_bits(8'hF0, 4);
    sel_high();
    rd_chk("R9 no rx after partial", 3'd1, 8'h12);
    sel_low();
    xfer(8'hE7, 8'h6E);
    sel_high();
    rd_chk("R9 R4 status after full byte", 3'd1, 8'h1B);
    rd_chk("R9 rx aligned", 3'd2, 8'hE7);

    // interrupts
    reg_wr(3'd4, 8'h10);
    rd_chk("R8 mask set", 3'd6, 8'h10);
    chk("R8 irq quiet", {7'b0, irq_o}, 8'h00);
    reg_wr(3'd3, 8'h55);
    sel_low();
    xfer(8'h00, 8'h55);
    sel_high();
    chk("R8 irq on release", {7'b0, irq_o}, 8'h01);
    reg_wr(3'd5, 8'h10);
    wait_clk(1);
    chk("R8 irq disabled", {7'b0, irq_o}, 8'h00);
    rd_chk("R8 mask cleared", 3'd6, 8'h00);
    reg_wr(3'd4, 8'h01);
    wait_clk(1);
    chk("R8 irq on rx full", {7'b0, irq_o}, 8'h01);
    rd_chk("R5 rx byte", 3'd2, 8'h00);
    wait_clk(1);
    chk("R8 irq after rx read", {7'b0, irq_o}, 8'h00);
    rd_chk("R7 select flag pending", 3'd1, 8'h12);

    chk("R1 all bytes seen", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule